// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter Chain

This block keeps wall-clock time and the calendar date as eight packed-BCD bytes: hundredths, seconds, minutes, hours, day of month, month, year and weekday. All eight registers share one clock. A one-cycle enable, `tick_100hz`, advances them. A prescaler outside the block derives that enable from a 32.768 kHz reference. Carries ripple combinationally down the chain within the same cycle, so every byte that changes on a tick updates at the same clock edge.

The hours byte runs in one of two modes. In 24-hour mode it counts 00 to 23. In 12-hour mode it counts 12, 01 ... 11 and keeps a PM flag in bit 7. The day-of-month limit follows the month and whether the year is a leap year.

A host can load any byte by address and read any byte back. The interrupt logic receives a one-cycle strobe per counter, one for each time that counter wraps.

Top module: `bcd_calendar`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every byte reads 00, except day of month, month and weekday, which read 01. `wrap_strb` reads 00.
- R2: The hundredths byte (address 0) counts 00..99 in BCD, advancing once per cycle in which `tick_100hz` is high. From 99 it returns to 00 and carries into seconds.
- R3: The seconds byte (address 1) and the minutes byte (address 2) each count 00..59. Each returns to 00 and carries into the next byte up.
- R4: With `mode_12h` low, the hours byte (address 3) counts 00..23 with bit 7 clear. From 23 it returns to 00 and carries into day of month and weekday.
- R5: With `mode_12h` high, bits 6:0 of the hours byte hold BCD 01..12 and bit 7 holds the PM flag (0 = AM, 1 = PM). Hours 11 step to 12 and the flag inverts. Hours 12 step to 01. A carry into the day occurs only when the hour steps from 11 PM to 12 AM.
- R6: The weekday byte (address 7) counts 01..07. On each day carry, 07 steps to 01.
- R7: The day-of-month byte (address 4) counts from 01 up to the month's length and then returns to 01, carrying into the month. The length is 30 for months 04, 06, 09 and 11, is 28 or 29 for month 02, and is 31 otherwise.
- R8: February has 29 days when the binary value of the BCD year is a multiple of 4, and 28 days otherwise.
- R9: The month byte (address 5) counts 01..12 and returns to 01 with a carry into the year. The year byte (address 6) counts 00..99 and returns to 00.
- R10: When `wr_en` is high, the byte at `addr` takes `wr_data` at the next clock edge. Any carry arriving at that byte in the same cycle is dropped, and that byte produces no carry. `rd_data` always shows the byte at `addr`. A byte that is neither written nor advanced holds its value.
- R11: `wrap_strb[i]` is high for exactly the one cycle that follows the clock edge at which the byte at address i wrapped back to its lowest value through counting. Bit 0 therefore serves as a once-per-second event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_100hz | input | 1 | One-cycle enable at the 100 Hz rate |
| mode_12h | input | 1 | 1 selects 12-hour counting, 0 selects 24-hour counting |
| wr_en | input | 1 | Host load strobe |
| addr | input | 3 | Byte select for load and readback |
| wr_data | input | 8 | BCD value to load |
| rd_data | output | 8 | Byte selected by `addr` |
| wrap_strb | output | 8 | Per-byte wrap pulse, indexed by address |

## Verification
The chain has no size parameter: eight fixed BCD bytes are the entire configuration, and the bench builds the package defaults. At that size the bench can sweep every step of the hundredths, seconds and minutes bytes. It also covers all 24 hour steps in each mode, every weekday, and both the last day and the day before it for all twelve months across eight consecutive years. Leap and common Februaries, the year wrap and load/carry collisions therefore each get an exact arithmetic expectation.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int CNT_NUM = 8;
    localparam int ADDR_W  = $clog2(CNT_NUM);
    localparam int BYTE_W  = 8;

    typedef logic [BYTE_W-1:0] bcd_t;

    typedef enum logic [ADDR_W-1:0] {
        IDX_CENT = 3'd0,
        IDX_SEC  = 3'd1,
        IDX_MIN  = 3'd2,
        IDX_HOUR = 3'd3,
        IDX_MDAY = 3'd4,
        IDX_MON  = 3'd5,
        IDX_YEAR = 3'd6,
        IDX_WDAY = 3'd7
    } cnt_idx_e;

    typedef struct packed {
        logic inc;
        logic ld;
        bcd_t val;
    } cnt_ctl_t;

    function automatic bcd_t bcd_inc(bcd_t v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic bcd_t cnt_floor(int i);
        if (i == int'(IDX_MDAY) || i == int'(IDX_MON) || i == int'(IDX_WDAY))
            return 8'h01;
        return 8'h00;
    endfunction

    function automatic bcd_t cnt_ceil(int i);
        case (i)
            int'(IDX_CENT): return 8'h99;
            int'(IDX_SEC):  return 8'h59;
            int'(IDX_MIN):  return 8'h59;
            int'(IDX_HOUR): return 8'h23;
            int'(IDX_MON):  return 8'h12;
            int'(IDX_YEAR): return 8'h99;
            int'(IDX_WDAY): return 8'h07;
            default:        return 8'h31;
        endcase
    endfunction

    function automatic logic leap_year(bcd_t y);
        int bin;
        bin = int'(y[7:4]) * 10 + int'(y[3:0]);
        return (bin % 4) == 0;
    endfunction

    function automatic bcd_t month_len(bcd_t mon, bcd_t yr);
        case (mon)
            8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_bcd_counter.sv
module cal_bcd_counter
    import cal_pkg::*;
#(
    parameter bcd_t FLOOR = 8'h00
) (
    input  logic     clk,
    input  logic     rst,
    input  cnt_ctl_t ctl,
    input  bcd_t     ceil_i,
    output bcd_t     q,
    output logic     full
);

    assign full = (q >= ceil_i);

    always_ff @(posedge clk) begin
        if (rst)          q <= FLOOR;
        else if (ctl.ld)  q <= ctl.val;
        else if (ctl.inc) q <= full ? FLOOR : bcd_inc(q);
    end

    AST_WRAP_TO_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (ctl.inc && !ctl.ld && full) |=> (q == FLOOR)); // R2
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        ctl.ld |=> (q == $past(ctl.val))); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ctl.inc && !ctl.ld) |=> $stable(q)); // R10

endmodule

// File: rtl/cal_hour_counter.sv
module cal_hour_counter
    import cal_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     mode_12h,
    input  cnt_ctl_t ctl,
    output bcd_t     q,
    output logic     full
);

    logic       pm;
    logic [6:0] hv;
    bcd_t       inc_v;
    bcd_t       nxt;

    assign pm    = q[7];
    assign hv    = q[6:0];
    assign inc_v = bcd_inc({1'b0, hv});

    always_comb begin
        if (mode_12h) begin
            full = pm && (hv == 7'h11);
            if (hv == 7'h11)      nxt = {~pm, 7'h12};
            else if (hv >= 7'h12) nxt = {pm, 7'h01};
            else                  nxt = {pm, inc_v[6:0]};
        end else begin
            full = (q >= 8'h23);
            nxt  = full ? 8'h00 : {1'b0, inc_v[6:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          q <= 8'h00;
        else if (ctl.ld)  q <= ctl.val;
        else if (ctl.inc) q <= nxt;
    end

    AST_H24_MSB_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (!mode_12h && ctl.inc && !ctl.ld) |=> !q[7]); // R4
    AST_H12_NOON_FLIP: assert property (@(posedge clk) disable iff (rst)
        (mode_12h && ctl.inc && !ctl.ld && hv == 7'h11) |=> (q[7] != $past(q[7]))); // R5
    AST_H12_DAY_WRAP: assert property (@(posedge clk) disable iff (rst)
        (mode_12h && ctl.inc && !ctl.ld && full) |=> (q == 8'h12)); // R5
    AST_HOUR_LOAD: assert property (@(posedge clk) disable iff (rst)
        ctl.ld |=> (q == $past(ctl.val))); // R10

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_100hz,
    input  logic              mode_12h,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic [CNT_NUM-1:0] wrap_strb
);

    bcd_t               cnt_q [CNT_NUM];
    cnt_ctl_t           ctl   [CNT_NUM];
    logic [CNT_NUM-1:0] cnt_full;
    logic [CNT_NUM-1:0] cnt_ld;
    logic [CNT_NUM-1:0] cnt_inc;
    logic [CNT_NUM-1:0] cnt_carry;
    bcd_t               mday_ceil;

    assign mday_ceil = month_len(cnt_q[IDX_MON], cnt_q[IDX_YEAR]);

    // Carry chain evaluated in order inside one block: no loop between drivers.
    always_comb begin
        for (int i = 0; i < CNT_NUM; i++) cnt_ld[i] = wr_en && (addr == ADDR_W'(i));
        cnt_inc   = '0;
        cnt_carry = '0;
        cnt_inc[IDX_CENT]   = tick_100hz;
        cnt_carry[IDX_CENT] = cnt_inc[IDX_CENT] && cnt_full[IDX_CENT] && !cnt_ld[IDX_CENT];
        cnt_inc[IDX_SEC]    = cnt_carry[IDX_CENT];
        cnt_carry[IDX_SEC]  = cnt_inc[IDX_SEC]  && cnt_full[IDX_SEC]  && !cnt_ld[IDX_SEC];
        cnt_inc[IDX_MIN]    = cnt_carry[IDX_SEC];
        cnt_carry[IDX_MIN]  = cnt_inc[IDX_MIN]  && cnt_full[IDX_MIN]  && !cnt_ld[IDX_MIN];
        cnt_inc[IDX_HOUR]   = cnt_carry[IDX_MIN];
        cnt_carry[IDX_HOUR] = cnt_inc[IDX_HOUR] && cnt_full[IDX_HOUR] && !cnt_ld[IDX_HOUR];
        cnt_inc[IDX_WDAY]   = cnt_carry[IDX_HOUR];
        cnt_carry[IDX_WDAY] = cnt_inc[IDX_WDAY] && cnt_full[IDX_WDAY] && !cnt_ld[IDX_WDAY];
        cnt_inc[IDX_MDAY]   = cnt_carry[IDX_HOUR];
        cnt_carry[IDX_MDAY] = cnt_inc[IDX_MDAY] && cnt_full[IDX_MDAY] && !cnt_ld[IDX_MDAY];
        cnt_inc[IDX_MON]    = cnt_carry[IDX_MDAY];
        cnt_carry[IDX_MON]  = cnt_inc[IDX_MON]  && cnt_full[IDX_MON]  && !cnt_ld[IDX_MON];
        cnt_inc[IDX_YEAR]   = cnt_carry[IDX_MON];
        cnt_carry[IDX_YEAR] = cnt_inc[IDX_YEAR] && cnt_full[IDX_YEAR] && !cnt_ld[IDX_YEAR];
        for (int i = 0; i < CNT_NUM; i++)
            ctl[i] = '{inc: cnt_inc[i], ld: cnt_ld[i], val: wr_data};
    end

    for (genvar i = 0; i < CNT_NUM; i++) begin : g_cnt
        if (i == int'(IDX_HOUR)) begin : g_hour
            cal_hour_counter u_hour (
                .clk      (clk),
                .rst      (rst),
                .mode_12h (mode_12h),
                .ctl      (ctl[i]),
                .q        (cnt_q[i]),
                .full     (cnt_full[i])
            );
        end else begin : g_plain
            bcd_t ceil_v;
            if (i == int'(IDX_MDAY)) begin : g_dyn
                assign ceil_v = mday_ceil;
            end else begin : g_fix
                assign ceil_v = cnt_ceil(i);
            end
            cal_bcd_counter #(.FLOOR(cnt_floor(i))) u_cnt (
                .clk    (clk),
                .rst    (rst),
                .ctl    (ctl[i]),
                .ceil_i (ceil_v),
                .q      (cnt_q[i]),
                .full   (cnt_full[i])
            );
        end
    end

    always_ff @(posedge clk) begin
        if (rst) wrap_strb <= '0;
        else     wrap_strb <= cnt_carry;
    end

    assign rd_data = cnt_q[addr];

    AST_STRB_CHAIN: assert property (@(posedge clk) disable iff (rst)
        wrap_strb[IDX_SEC] |-> wrap_strb[IDX_CENT]); // R11
    AST_MON_NEEDS_MDAY: assert property (@(posedge clk) disable iff (rst)
        wrap_strb[IDX_MON] |-> wrap_strb[IDX_MDAY]); // R9
    AST_MDAY_RANGE: assert property (@(posedge clk) disable iff (rst)
        (cnt_inc[IDX_MDAY] && !cnt_ld[IDX_MDAY] && cnt_q[IDX_MDAY] < mday_ceil)
        |=> (cnt_q[IDX_MDAY] <= month_len(cnt_q[IDX_MON], cnt_q[IDX_YEAR]))); // R7

endmodule

// File: tb/bcd_calendar_test.sv
`timescale 1ns/100ps
module bcd_calendar_test;
    import cal_pkg::*;

    logic       clk = 1'b0;
    logic       rst, tick, mode, wr_en;
    logic [2:0] addr;
    logic [7:0] wr_data, rd_data, strb;
    int total = 0;
    int failed = 0;

    always #2 clk = ~clk;

    bcd_calendar uut (
        .clk(clk), .rst(rst), .tick_100hz(tick), .mode_12h(mode), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .wrap_strb(strb)
    );

    function automatic logic [7:0] bcd(int n);
        return 8'(((n / 10) << 4) | (n % 10));
    endfunction

    function automatic logic [7:0] h12(int s);
        int h = s % 12;
        logic [7:0] b;
        if (h == 0) h = 12;
        b = bcd(h);
        return {(s >= 12) ? 1'b1 : 1'b0, b[6:0]};
    endfunction

    function automatic int mlen(int m, int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            failed++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic chk_rd(input string tag, input int a, input logic [7:0] exp);
        addr = 3'(a);
        #0.1;
        chk(tag, rd_data, exp);
    endtask

    task automatic put(input int a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = 3'(a); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic end_of_day(input logic [7:0] hr);
        put(IDX_CENT, 8'h99);
        put(IDX_SEC, 8'h59);
        put(IDX_MIN, 8'h59);
        put(IDX_HOUR, hr);
    endtask

    task automatic run_all();
        logic [7:0] exp_s;
        int nm, ny, nw;
        repeat (3) @(negedge clk);
        chk("R1 strobe in reset", strb, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        for (int i = 0; i < 8; i++)
            chk_rd("R1 reset byte", i, (i == 4 || i == 5 || i == 7) ? 8'h01 : 8'h00);
        chk("R1 strobe after reset", strb, 8'h00);

        // R2 full hundredths sweep
        for (int k = 1; k <= 100; k++) begin
            step();
            chk("R2 strobe", strb, (k == 100) ? 8'h01 : 8'h00);
            chk_rd("R2 hundredths", IDX_CENT, bcd(k % 100));
        end
        chk_rd("R2 carry into seconds", IDX_SEC, 8'h01);

        // R3 seconds sweep
        put(IDX_MIN, 8'h00);
        for (int s = 0; s < 60; s++) begin
            put(IDX_CENT, 8'h99);
            put(IDX_SEC, bcd(s));
            step();
            chk("R3 sec strobe", strb, (s == 59) ? 8'h03 : 8'h01);
            chk_rd("R3 seconds", IDX_SEC, bcd((s + 1) % 60));
        end
        chk_rd("R3 carry into minutes", IDX_MIN, 8'h01);

        // R3 minutes sweep
        put(IDX_HOUR, 8'h00);
        for (int m = 0; m < 60; m++) begin
            put(IDX_CENT, 8'h99);
            put(IDX_SEC, 8'h59);
            put(IDX_MIN, bcd(m));
            step();
            chk("R3 min strobe", strb, (m == 59) ? 8'h07 : 8'h03);
            chk_rd("R3 minutes", IDX_MIN, bcd((m + 1) % 60));
        end
        chk_rd("R3 carry into hours", IDX_HOUR, 8'h01);

        // R4 24-hour sweep
        mode = 1'b0;
        put(IDX_MDAY, 8'h05); put(IDX_MON, 8'h01); put(IDX_YEAR, 8'h01); put(IDX_WDAY, 8'h01);
        for (int h = 0; h < 24; h++) begin
            end_of_day(bcd(h));
            step();
            chk("R4 hour strobe", strb[3], (h == 23) ? 8'h01 : 8'h00);
            chk_rd("R4 hours", IDX_HOUR, bcd((h + 1) % 24));
        end
        chk_rd("R4 day carry mday", IDX_MDAY, 8'h06);
        chk_rd("R4 day carry wday", IDX_WDAY, 8'h02);

        // R5 12-hour sweep
        mode = 1'b1;
        for (int s = 0; s < 24; s++) begin
            end_of_day(h12(s));
            step();
            chk("R5 day strobe", strb[3], (s == 23) ? 8'h01 : 8'h00);
            chk_rd("R5 hours 12h", IDX_HOUR, h12((s + 1) % 24));
        end
        chk_rd("R5 day carry mday", IDX_MDAY, 8'h07);
        mode = 1'b0;

        // R6 weekday sweep
        for (int w = 1; w <= 7; w++) begin
            put(IDX_WDAY, bcd(w));
            end_of_day(8'h23);
            step();
            chk("R6 weekday strobe", strb[7], (w == 7) ? 8'h01 : 8'h00);
            chk_rd("R6 weekday", IDX_WDAY, bcd((w == 7) ? 1 : w + 1));
        end

        // R7 R8 R9 month-end sweep over eight years
        for (int y = 0; y < 8; y++) begin
            for (int m = 1; m <= 12; m++) begin
                for (int last = 0; last < 2; last++) begin
                    put(IDX_YEAR, bcd(y));
                    put(IDX_MON, bcd(m));
                    put(IDX_MDAY, bcd(mlen(m, y) - 1 + last));
                    put(IDX_WDAY, 8'h03);
                    end_of_day(8'h23);
                    step();
                    exp_s = 8'h0F;
                    if (last == 1) exp_s = exp_s | 8'h10 | ((m == 12) ? 8'h20 : 8'h00);
                    chk("R11 strobe vector", strb, exp_s);
                    nm = (last == 1) ? ((m == 12) ? 1 : m + 1) : m;
                    ny = (last == 1 && m == 12) ? y + 1 : y;
                    chk_rd((m == 2) ? "R8 february mday" : "R7 mday", IDX_MDAY,
                           (last == 1) ? 8'h01 : bcd(mlen(m, y)));
                    chk_rd("R9 month", IDX_MON, bcd(nm));
                    chk_rd("R9 year", IDX_YEAR, bcd(ny));
                end
            end
        end
        @(negedge clk);
        chk("R11 strobe lasts one cycle", strb, 8'h00);

        // R9 year wrap
        put(IDX_YEAR, 8'h99); put(IDX_MON, 8'h12); put(IDX_MDAY, 8'h31); put(IDX_WDAY, 8'h07);
        end_of_day(8'h23);
        step();
        chk("R11 full wrap strobe", strb, 8'hFF);
        chk_rd("R9 year wrap", IDX_YEAR, 8'h00);
        chk_rd("R9 month wrap", IDX_MON, 8'h01);
        chk_rd("R6 wday wrap", IDX_WDAY, 8'h01);

        // R10 load collides with a carry into the same byte
        put(IDX_SEC, 8'h10);
        put(IDX_CENT, 8'h99);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; addr = 3'(IDX_SEC); wr_data = 8'h30;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        chk("R10 strobe on collision", strb, 8'h01);
        chk_rd("R10 load beats carry", IDX_SEC, 8'h30);
        chk_rd("R10 hundredths still wrap", IDX_CENT, 8'h00);

        // R10 load collides with the tick on the hundredths byte
        put(IDX_SEC, 8'h59);
        put(IDX_CENT, 8'h99);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; addr = 3'(IDX_CENT); wr_data = 8'h50;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        chk("R10 no strobe under load", strb, 8'h00);
        chk_rd("R10 hundredths loaded", IDX_CENT, 8'h50);
        chk_rd("R10 seconds untouched", IDX_SEC, 8'h59);

        // R10 idle hold
        repeat (5) @(negedge clk);
        chk_rd("R10 hold without tick", IDX_CENT, 8'h50);
    endtask

    initial begin
        rst = 1'b1; tick = 1'b0; mode = 1'b0; wr_en = 1'b0; addr = '0; wr_data = '0;
        fork
            begin : main_flow
                run_all();
            end
            begin : watchdog
                repeat (150000) @(posedge clk);
                failed++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", total, failed);
        $finish;
    end

endmodule